// File: doc/BRIEF.md
# AES-128 Round-Key Schedule Store

This block expands a 128-bit cipher key into all eleven AES-128 round keys in a short phase before any encryption starts. It keeps every result in local storage so that an encryption datapath can fetch any round key by index, as often as it needs to. The key is expanded once and then reused for every data block under that key, so no round keys are derived while blocks are encrypted.

A single-cycle strobe starts the expansion. The block stores the cipher key as round key 0 at the edge that accepts the strobe. At each of the next ten edges it derives one further 128-bit round key, four schedule words at a time. A busy flag covers the expansion phase. A done flag then marks the stored schedule as valid until the next accepted start. A combinational read port returns the stored entry for a given index.

Top module: `keysched_store`

## Requirements
- R1: After a synchronous active-low reset, busy and done are 0 and every read index returns zero.
- R2: A start pulse sampled while busy is 0 is accepted. From the next cycle, index 0 returns the key presented with it. Key byte 0 sits in bits [127:120], and schedule word j of an entry sits in bits [127-32j -: 32].
- R3: Busy rises at the edge that accepts start and stays high for ten further edges. At the tenth of these edges, which writes index 10, busy falls and done rises, so the phase lasts 11 edges. Busy and done are never both high.
- R4: Word 0 of round key r (1..10) equals word 0 of key r-1 XOR the value built from word 3 of key r-1 in three steps: its bytes rotated one position left, each byte passed through the AES S-box, and the round constant XORed into the top byte.
- R5: Words 1 to 3 of round key r each equal the previous word of key r XOR the same-position word of key r-1.
- R6: The round constants for keys 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 in hexadecimal.
- R7: A start pulse that arrives while busy is 1 is ignored. Timing and stored keys stay those of the running expansion.
- R8: Once done is 1, it stays 1 and the stored schedule stays unchanged until a new start is accepted. Accepting a new start clears done and regenerates all entries from the new key.
- R9: Read indices 11 to 15 return zero.
- R10: A reset during expansion returns the block to idle, with busy and done at 0 and all entries cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin expansion of key_in (accepted only while idle) |
| key_in | input | 128 | Cipher key, byte 0 in the top bits |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | Complete schedule held in storage |
| rd_idx | input | 4 | Round-key index to read |
| rd_key | output | 128 | Stored round key at rd_idx, zero if out of range |

## Verification
The bench uses the default ROUND_KEYS of 11, which gives a 4-bit read index. The five unused codes 11 to 15 can therefore be driven, which exercises the out-of-range read. The standard published example key checks every word of all eleven entries, so every S-box lookup path and every step of the round-constant doubling, including its wrap to 1B and 36, is compared. An all-zero key tests the S-box at input zero and gives a second set of known values after a restart.

// File: rtl/ks_pkg.sv
// Package: shared widths and GF(2^8) helpers for the round-key schedule store.
// Assumes AES field polynomial x^8+x^4+x^3+x+1; S-box is computed, not tabled.
package ks_pkg;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 128;
    localparam int NK     = KEY_W / WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  rkey_t;

    // Multiply by x in GF(2^8).
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General GF(2^8) multiply by shift-and-add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // S-box: multiplicative inverse (a^254) followed by the affine map.
    function automatic logic [7:0] sbox_calc(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = a;
        inv = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/ks_sbox.sv
// Module: one byte substitution, purely combinational.
// Assumes the caller registers the result; depth is the inverse chain.
module ks_sbox (
    input  logic [7:0] in_byte,
    output logic [7:0] out_byte
);
    import ks_pkg::*;

    // Substitute one byte.
    always_comb begin
        out_byte = sbox_calc(in_byte);
    end
endmodule

// File: rtl/ks_step.sv
// Module: derives round key r from round key r-1 in one combinational pass.
// Assumes big-endian packing: word j at bits [KEY_W-1-WORD_W*j -: WORD_W].
module ks_step (
    input  logic [127:0] prev_key,
    input  logic [7:0]   rcon,
    output logic [127:0] next_key
);
    import ks_pkg::*;

    localparam int BYTES = WORD_W / 8;

    word_t prev_w [NK];
    word_t next_w [NK];
    word_t rot_w;
    word_t sub_w;
    word_t temp_w;

    // Split the previous key into words.
    always_comb begin
        for (int j = 0; j < NK; j++) begin
            prev_w[j] = prev_key[KEY_W-1-WORD_W*j -: WORD_W];
        end
    end

    // Rotate the last word one byte towards the top.
    always_comb begin
        rot_w = {prev_w[NK-1][WORD_W-9:0], prev_w[NK-1][WORD_W-1 -: 8]};
    end

    genvar b;
    generate
        for (b = 0; b < BYTES; b++) begin : g_sub
            ks_sbox u_sbox (
                .in_byte  (rot_w[8*b +: 8]),
                .out_byte (sub_w[8*b +: 8])
            );
        end
    endgenerate

    // Fold in the round constant at the top byte.
    always_comb begin
        temp_w = sub_w ^ {rcon, {(WORD_W-8){1'b0}}};
    end

    genvar j;
    generate
        for (j = 0; j < NK; j++) begin : g_chain
            if (j == 0) begin : g_first
                assign next_w[j] = prev_w[j] ^ temp_w;
            end else begin : g_rest
                assign next_w[j] = prev_w[j] ^ next_w[j-1];
            end
            assign next_key[KEY_W-1-WORD_W*j -: WORD_W] = next_w[j];
        end
    endgenerate
endmodule

// File: rtl/ks_store.sv
// Module: register file of ENTRIES round keys, one write port, one
// combinational read port that returns zero for indices past the last entry.
// Assumes synchronous active-low reset clears all entries.
module ks_store #(
    parameter int ENTRIES = 11,
    parameter int WIDTH   = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [ENTRIES];

    // Clear on reset, otherwise write the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_en && (32'(wr_idx) < ENTRIES)) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read the addressed entry, zero when out of range.
    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < ENTRIES) rd_data = mem[rd_idx];
    end

    // R2 R4 R5: a written key is the one held at that index afterwards.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) < ENTRIES)) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/keysched_store.sv
// Module: top of the round-key schedule store. Accepts a key on start,
// writes it as entry 0, then derives and writes one round key per cycle.
// Assumes start is ignored while busy; done holds until the next start.
module keysched_store #(
    parameter int ROUND_KEYS = 11,
    localparam int IDX_W     = $clog2(ROUND_KEYS),
    localparam int CNT_W     = $clog2(ROUND_KEYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [127:0]     key_in,
    output logic             busy,
    output logic             done,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [127:0]     rd_key
);
    import ks_pkg::*;

    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ROUND_KEYS - 1);

    rkey_t            cur_key_q;
    rkey_t            next_key;
    logic [7:0]       rcon_q;
    logic [CNT_W-1:0] step_q;
    logic             busy_q;
    logic             done_q;
    logic             accept;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    rkey_t            wr_data;

    ks_step u_step (
        .prev_key (cur_key_q),
        .rcon     (rcon_q),
        .next_key (next_key)
    );

    // Decide whether a start is taken this cycle.
    always_comb begin
        accept = start && !busy_q;
    end

    // Sequence the expansion: load, step, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_key_q <= '0;
            rcon_q    <= 8'h00;
            step_q    <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
        end else if (accept) begin
            cur_key_q <= key_in;
            rcon_q    <= 8'h01;
            step_q    <= CNT_W'(1);
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
        end else if (busy_q) begin
            cur_key_q <= next_key;
            rcon_q    <= gf_x2(rcon_q);
            step_q    <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // Route either the raw key or the derived key to storage.
    always_comb begin
        wr_en   = accept || busy_q;
        wr_idx  = accept ? '0 : IDX_W'(step_q);
        wr_data = accept ? key_in : next_key;
    end

    ks_store #(
        .ENTRIES (ROUND_KEYS),
        .WIDTH   (KEY_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_key)
    );

    assign busy = busy_q;
    assign done = done_q;

    // R3: the two phase flags never overlap.
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));

    // R3: leaving the busy phase without a reset always lands on done.
    assert_done_on_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && $past(rst_n)) |-> done_q);

    // R7: a start during expansion does not disturb the step count.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && step_q != LAST_STEP) |=>
            (busy_q && step_q == CNT_W'($past(step_q) + 1'b1)));

    // R8: done holds until a new start arrives.
    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !start) |=> done_q);

    // R6: the round constant stays a single set bit for the first eight steps.
    assert_rcon_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && step_q <= CNT_W'(8)) |-> ($countones(rcon_q) == 1));
endmodule

// File: tb/keysched_store_bench.sv
// Bench: directed scenarios, one task each, checked against published and
// hand-derived AES-128 schedules.
module keysched_store_bench;
    localparam int HALF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key_in = '0;
    logic         busy;
    logic         done;
    logic [3:0]   rd_idx = '0;
    logic [127:0] rd_key;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [127:0] FIPS_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

    keysched_store u_keysched_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .key_in (key_in),
        .busy   (busy),
        .done   (done),
        .rd_idx (rd_idx),
        .rd_key (rd_key)
    );

    always #HALF clk = ~clk;

    // Expected schedule for the published example key.
    function automatic logic [127:0] fips_rk(input int i);
        case (i)
            0:  return 128'h2b7e151628aed2a6abf7158809cf4f3c;
            1:  return 128'ha0fafe1788542cb123a339392a6c7605;
            2:  return 128'hf2c295f27a96b9435935807a7359f67f;
            3:  return 128'h3d80477d4716fe3e1e237e446d7a883b;
            4:  return 128'hef44a541a8525b7fb671253bdb0bad00;
            5:  return 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
            6:  return 128'h6d88a37a110b3efddbf98641ca0093fd;
            7:  return 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
            8:  return 128'head27321b58dbad2312bf5607f8d292f;
            9:  return 128'hac7766f319fadc2128d12941575c006e;
            default: return 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
        endcase
    endfunction

    // Expected schedule entries for the all-zero key.
    function automatic logic [127:0] zero_rk(input int i);
        case (i)
            1:  return 128'h62636363626363636263636362636363;
            2:  return 128'h9b9898c9f9fbfbaa9b9898c9f9fbfbaa;
            10: return 128'hb4ef5bcb3e92e21123e951cf6f8f188e;
            default: return 128'h0;
        endcase
    endfunction

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_key(input string req, input int idx, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s index %0d actual=%h expected=%h", req, idx, act, exp);
        end
    endtask

    // Read one entry in the low phase.
    task automatic read_rk(input int idx, output logic [127:0] val);
        rd_idx = 4'(idx);
        #1;
        val = rd_key;
    endtask

    // Present a key with a one-cycle start; returns just after the accepting edge.
    task automatic launch(input logic [127:0] k);
        @(negedge clk);
        key_in = k;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // Compare all entries with the example schedule, word 0 tagged R4/R6, rest R5.
    task automatic cmp_fips(input string tag);
        logic [127:0] v;
        for (int i = 0; i < 11; i++) begin
            read_rk(i, v);
            if (i == 0) chk_key({tag, " R2"}, i, v, fips_rk(i));
            else begin
                chk_key({tag, " R4 R6 word0"}, i, {v[127:96], 96'h0}, {fips_rk(i) & {32'hffffffff, 96'h0}});
                chk_key({tag, " R5 words1-3"}, i, {32'h0, v[95:0]}, {fips_rk(i) & {32'h0, {96{1'b1}}}});
            end
        end
    endtask

    task automatic t_reset_state;
        logic [127:0] v;
        @(negedge clk);
        chk_bit("R1", "busy", busy, 1'b0);
        chk_bit("R1", "done", done, 1'b0);
        for (int i = 0; i < 16; i++) begin
            read_rk(i, v);
            chk_key("R1", i, v, 128'h0);
        end
    endtask

    task automatic t_example_key;
        logic [127:0] v;
        launch(FIPS_KEY);
        chk_bit("R3", "busy after accept", busy, 1'b1);
        chk_bit("R3", "done after accept", done, 1'b0);
        read_rk(0, v);
        chk_key("R2", 0, v, FIPS_KEY);
        for (int s = 1; s <= 10; s++) begin
            @(negedge clk);
            chk_bit("R3", $sformatf("busy after edge %0d", s), busy, s < 10);
            chk_bit("R3", $sformatf("done after edge %0d", s), done, s == 10);
        end
        cmp_fips("example");
    endtask

    task automatic t_hold_and_range;
        logic [127:0] v;
        repeat (5) @(negedge clk);
        chk_bit("R8", "done held", done, 1'b1);
        chk_bit("R8", "busy stays low", busy, 1'b0);
        read_rk(7, v);
        chk_key("R8", 7, v, fips_rk(7));
        for (int i = 11; i < 16; i++) begin
            read_rk(i, v);
            chk_key("R9", i, v, 128'h0);
        end
    endtask

    task automatic t_restart_zero_key;
        logic [127:0] v;
        launch(128'h0);
        chk_bit("R8", "done cleared by new start", done, 1'b0);
        chk_bit("R8", "busy on restart", busy, 1'b1);
        repeat (10) @(negedge clk);
        chk_bit("R8", "done after regeneration", done, 1'b1);
        read_rk(0, v);
        chk_key("R8 R2", 0, v, 128'h0);
        for (int i = 1; i < 11; i++) begin
            if (i == 1 || i == 2 || i == 10) begin
                read_rk(i, v);
                chk_key("R8 R4 R5 R6 zero key", i, v, zero_rk(i));
            end
        end
    endtask

    task automatic t_start_while_busy;
        launch(FIPS_KEY);
        repeat (3) @(negedge clk);
        key_in = 128'hffffffff_ffffffff_ffffffff_ffffffff;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        chk_bit("R7", "busy after ignored start", busy, 1'b1);
        repeat (5) @(negedge clk);
        chk_bit("R7", "busy after edge 9", busy, 1'b1);
        @(negedge clk);
        chk_bit("R7", "busy after edge 10", busy, 1'b0);
        chk_bit("R7", "done after edge 10", done, 1'b1);
        cmp_fips("R7");
    endtask

    task automatic t_reset_midrun;
        logic [127:0] v;
        launch(FIPS_KEY);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_bit("R10", "busy after reset", busy, 1'b0);
        chk_bit("R10", "done after reset", done, 1'b0);
        read_rk(0, v);
        chk_key("R10", 0, v, 128'h0);
        read_rk(3, v);
        chk_key("R10", 3, v, 128'h0);
        repeat (12) @(negedge clk);
        chk_bit("R10", "stays idle", busy | done, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_example_key();
        t_hold_and_range();
        t_restart_zero_key();
        t_start_while_busy();
        t_reset_midrun();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule